// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer

A watchdog timer controlled through one 32-bit register. Software cannot arm, disarm or refresh it with a single write. Each of these actions needs two register writes that carry a fixed key pair in a dedicated 2-bit command field. One field toggles the run state. The other field services, or refreshes, the timer. This makes it unlikely that a runaway program stops or feeds the watchdog by accident.

While the timer runs, a down-counter is loaded from a 24-bit preset. The counter decrements once every 256 clocks. The preset is therefore the timeout in clocks divided by 256. The default preset is 0x4F4630, which is 10 s at a 133 MHz clock. When the count reaches zero, the block raises an expiry pulse for one clock and sets a reset request. The reset request stays set until the block is reset. The register reads back the run flag and the stored preset.

Top module: `keyseq_wdog`

## Requirements
- R1: After reset the timer is stopped, and the register reads 0x004F4630 (run flag 0, preset 0x4F4630). `expire_pulse` and `reset_req` are both 0.
- R2: A read returns the run flag in bit 31 and the preset in bits 23:0. All other bits read 0. Writing bit 31 or bits 30:28 has no effect.
- R3: Every write stores `wr_data[23:0]` as the new preset. The new preset is visible on `rd_data` in the cycle after the write.
- R4: The toggle field is bits 25:24. A write with value 01, followed by a write with value 10, inverts the run flag at the second write.
- R5: In either command field, the value 11 cancels a pending 01. A value of 10 with no 01 pending does nothing. The value 00 leaves a pending 01 in place.
- R6: The service field is bits 27:26. A write with value 01, followed by a write with value 10, reloads the down-counter from the preset and clears the 256-clock prescaler.
- R7: Suppose the counter is loaded with preset P at clock edge E, either by starting the timer or by a service. If the timer keeps running, `expire_pulse` is high for exactly the one cycle after edge E+256·P+1. `reset_req` rises at that same edge.
- R8: A write that changes only the preset does not change when the running count expires.
- R9: `reset_req` stays at 1 until reset, even after a service. Once the timer has expired, the counter stops and no further pulse occurs.
- R10: While the timer is stopped, it does not count and does not expire.
- R11: Starting the timer with a preset of 0 gives the expiry pulse one edge after the starting write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register read value: run flag and preset |
| expire_pulse | output | 1 | One-cycle pulse when the count reaches zero |
| reset_req | output | 1 | Reset request, set on expiry and held until reset |

## Verification
Register effects are due at the write's clock edge. The bench therefore reads `rd_data` at the falling edge right after that edge. The expiry pulse is due exactly 256·P+1 edges after the write that loaded the counter. The bench records the loading edge with a free-running edge counter and samples at the edge before the due one, at the due one, and at the one after. Long waits while the timer is stopped or already expired end with a look at `reset_req` and `rd_data`. A stray pulse during the wait would have left `reset_req` set, so it cannot go unseen.

// File: rtl/keyseq_wdog_pkg.sv
package keyseq_wdog_pkg;

  // Command field width and key values.
  localparam int KEY_W = 2;
  localparam logic [KEY_W-1:0] KEY_NOP    = 2'b00;
  localparam logic [KEY_W-1:0] KEY_FIRST  = 2'b01;
  localparam logic [KEY_W-1:0] KEY_SECOND = 2'b10;

  // Register field positions that software decodes.
  localparam int RUN_BIT    = 31;
  localparam int TOGGLE_LSB = 24;
  localparam int SERVE_LSB  = 26;
  localparam int NUM_KEYS   = 2;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_e;

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import keyseq_wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             wr_en_i,
  input  logic [KEY_W-1:0] field_i,
  output logic             fire_o
);

  key_state_e st_q, st_d;

  // Next-state logic: a 01 arms the field, and a following 10 fires it.
  always_comb begin
    st_d   = st_q;
    fire_o = 1'b0;
    if (wr_en_i) begin
      case (field_i)
        KEY_NOP:    st_d = st_q;
        KEY_FIRST:  st_d = KEY_ARMED;
        KEY_SECOND: begin
          fire_o = (st_q == KEY_ARMED);
          st_d   = KEY_IDLE;
        end
        default:    st_d = KEY_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q <= KEY_IDLE;
    end else if (wr_en_i) begin
      st_q <= st_d;
    end
  end

  // R5: a completed pair always leaves the field disarmed
  a_r5_fire_disarms: assert property (@(posedge clk) disable iff (!rst_sn)
    fire_o |=> (st_q == KEY_IDLE));

  // R5: a write with 00 in the field keeps the pending state
  a_r5_nop_holds: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en_i && field_i == KEY_NOP) |=> $stable(st_q));

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int               CNT_W   = 24,
  parameter int               PRESC_W = 8,
  parameter logic [CNT_W-1:0] CNT_RST = '0
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             run_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o,
  output logic             trip_o
);

  localparam logic [PRESC_W-1:0] PRESC_MAX = {PRESC_W{1'b1}};

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [PRESC_W-1:0] presc_q, presc_d;
  logic               trip_q, trip_d;
  logic               expire_q, expire_d;
  logic               hit_zero;

  assign hit_zero = (cnt_q == '0);

  // Next-state logic. Once expired, everything is frozen, and a reload
  // takes priority over counting.
  always_comb begin
    cnt_d    = cnt_q;
    presc_d  = presc_q;
    trip_d   = trip_q;
    expire_d = 1'b0;
    if (!trip_q) begin
      if (reload_i) begin
        cnt_d   = load_val_i;
        presc_d = '0;
      end else if (run_i) begin
        if (hit_zero) begin
          trip_d   = 1'b1;
          expire_d = 1'b1;
        end else begin
          presc_d = presc_q + 1'b1;
          if (presc_q == PRESC_MAX) begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q    <= CNT_RST;
      presc_q  <= '0;
      trip_q   <= 1'b0;
      expire_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      presc_q  <= presc_d;
      trip_q   <= trip_d;
      expire_q <= expire_d;
    end
  end

  assign expire_o = expire_q;
  assign trip_o   = trip_q;

  // R7: the expiry pulse lasts a single cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_sn)
    expire_q |=> !expire_q);

  // R7: expiry only follows a count that had reached zero
  a_r7_from_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    expire_q |-> ($past(cnt_q) == '0));

  // R9: the reset request is sticky
  a_r9_req_sticky: assert property (@(posedge clk) disable iff (!rst_sn)
    trip_q |=> trip_q);

  // R9: the counter stays frozen after expiry
  a_r9_frozen_after_trip: assert property (@(posedge clk) disable iff (!rst_sn)
    trip_q |=> ($stable(cnt_q) && $stable(presc_q)));

  // R10: no counting while stopped and not reloading
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    (!run_i && !reload_i) |=> $stable(cnt_q));

  // R6: a reload lands the load value and clears the prescaler
  a_r6_reload_lands: assert property (@(posedge clk) disable iff (!rst_sn)
    (reload_i && !trip_q) |=> (cnt_q == $past(load_val_i) && presc_q == '0));

endmodule

// File: rtl/keyseq_wdog.sv
module keyseq_wdog
  import keyseq_wdog_pkg::*;
#(
  parameter int                  DATA_W     = 32,
  parameter int                  PRESET_W   = 24,
  parameter int                  PRESC_W    = 8,
  parameter logic [PRESET_W-1:0] PRESET_RST = 24'h4F4630
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              expire_pulse,
  output logic              reset_req
);

  localparam int TOGGLE_IDX = 0;
  localparam int SERVE_IDX  = 1;

  logic                rst_sn;
  logic                run_q, run_d;
  logic [PRESET_W-1:0] preset_q;
  logic [PRESET_W-1:0] preset_wr;
  logic [NUM_KEYS-1:0] fire;
  logic                reload;
  logic [3:0]          unused_high;

  assign unused_high = wr_data[DATA_W-1:DATA_W-4];
  assign preset_wr   = wr_data[PRESET_W-1:0];

  wdog_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  // One key tracker per command field.
  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_key
    localparam int LSB = (g == TOGGLE_IDX) ? TOGGLE_LSB : SERVE_LSB;
    wdog_key_seq u_key (
      .clk     (clk),
      .rst_sn  (rst_sn),
      .wr_en_i (wr_en),
      .field_i (wr_data[LSB +: KEY_W]),
      .fire_o  (fire[g])
    );
  end

  // The run flag toggles on a completed toggle pair.
  always_comb begin
    run_d = run_q ^ fire[TOGGLE_IDX];
  end

  // Starting the timer or a completed service reloads the counter.
  assign reload = (fire[TOGGLE_IDX] && !run_q) || fire[SERVE_IDX];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      run_q    <= 1'b0;
      preset_q <= PRESET_RST;
    end else if (wr_en) begin
      run_q    <= run_d;
      preset_q <= preset_wr;
    end
  end

  wdog_count #(
    .CNT_W   (PRESET_W),
    .PRESC_W (PRESC_W),
    .CNT_RST (PRESET_RST)
  ) u_count (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .run_i      (run_q),
    .reload_i   (reload),
    .load_val_i (preset_wr),
    .expire_o   (expire_pulse),
    .trip_o     (reset_req)
  );

  always_comb begin
    rd_data                 = '0;
    rd_data[RUN_BIT]        = run_q;
    rd_data[PRESET_W-1:0]   = preset_q;
  end

  // R4: a completed toggle pair inverts the run flag
  a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_sn)
    fire[TOGGLE_IDX] |=> (run_q != $past(run_q)));

  // R4: without a completed pair the run flag holds
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !fire[TOGGLE_IDX] |=> $stable(run_q));

  // R3: each write lands its preset bits
  a_r3_preset_store: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_en |=> (rd_data[PRESET_W-1:0] == $past(wr_data[PRESET_W-1:0])));

endmodule

// File: tb/keyseq_wdog_bench.sv
module keyseq_wdog_bench;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        expire_pulse;
  logic        reset_req;

  int n_checks;
  int n_fails;
  int cyc;
  int last_edge;

  keyseq_wdog u_keyseq_wdog (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .expire_pulse (expire_pulse),
    .reset_req    (reset_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Each entry holds {write data, expected read value after the write}.
  localparam int NVEC = 16;
  localparam logic [63:0] VEC [NVEC] = '{
    {32'h0000_0010, 32'h0000_0010},
    {32'h0100_0010, 32'h0000_0010},
    {32'h0200_0010, 32'h8000_0010},
    {32'h0100_0010, 32'h8000_0010},
    {32'h0300_0010, 32'h8000_0010},
    {32'h0200_0010, 32'h8000_0010},
    {32'h0100_0020, 32'h8000_0020},
    {32'h0000_0020, 32'h8000_0020},
    {32'h0200_0020, 32'h0000_0020},
    {32'hFC00_0030, 32'h0000_0030},
    {32'h0500_0030, 32'h0000_0030},
    {32'h0A00_0030, 32'h8000_0030},
    {32'h0200_0030, 32'h8000_0030},
    {32'h00FF_FFFF, 32'h80FF_FFFF},
    {32'h01FF_FFFF, 32'h80FF_FFFF},
    {32'h02FF_FFFF, 32'h00FF_FFFF}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    wr_en   = 1'b0;
    wr_data = '0;
    rst_n   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // One write lasts a single clock edge; last_edge records that edge.
  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    last_edge = cyc;
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  initial begin
    #1200000;
    n_fails++;
    $display("FAIL watchdog: bench did not finish");
    summary();
    $finish;
  end

  initial begin
    int e;
    do_reset();

    // R1 reset state
    chk("R1 rd_data", rd_data, 32'h004F_4630);
    chk("R1 expire_pulse", {31'b0, expire_pulse}, 32'd0);
    chk("R1 reset_req", {31'b0, reset_req}, 32'd0);

    // Register table: R2 R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][63:32]);
      chk($sformatf("R2 R3 R4 R5 R6 vector %0d rd_data", i), rd_data, VEC[i][31:0]);
      chk($sformatf("R7 vector %0d no early expiry", i), {31'b0, reset_req}, 32'd0);
    end

    // R11 preset zero
    do_reset();
    wr(32'h0100_0000);
    wr(32'h0200_0000);
    e = last_edge;
    chk("R11 no pulse at start edge", {31'b0, expire_pulse}, 32'd0);
    wait_until(e + 1);
    chk("R11 pulse one edge later", {30'b0, expire_pulse, reset_req}, 32'd3);
    wait_until(e + 2);
    chk("R9 pulse gone, request held", {30'b0, expire_pulse, reset_req}, 32'd1);

    // R7 exact expiry timing with P=3
    do_reset();
    wr(32'h0100_0003);
    wr(32'h0200_0003);
    e = last_edge;
    wait_until(e + 768);
    chk("R7 before due edge", {30'b0, expire_pulse, reset_req}, 32'd0);
    wait_until(e + 769);
    chk("R7 at due edge", {30'b0, expire_pulse, reset_req}, 32'd3);
    wait_until(e + 770);
    chk("R7 one cycle pulse", {30'b0, expire_pulse, reset_req}, 32'd1);

    // R9 stickiness: a service does not clear the request
    wait_until(e + 2000);
    wr(32'h0400_0003);
    wr(32'h0800_0003);
    wait_until(last_edge + 1000);
    chk("R9 request held after service", {30'b0, expire_pulse, reset_req}, 32'd1);

    // R10 stopped timer does not expire
    do_reset();
    wr(32'h0100_0001);
    wr(32'h0200_0001);
    e = last_edge;
    wait_until(e + 100);
    wr(32'h0100_0001);
    wr(32'h0200_0001);
    wait_until(last_edge + 600);
    chk("R10 no expiry while stopped", {30'b0, expire_pulse, reset_req}, 32'd0);
    chk("R10 stopped flag", rd_data, 32'h0000_0001);

    // R6 service reloads the count
    do_reset();
    wr(32'h0100_0002);
    wr(32'h0200_0002);
    e = last_edge;
    wait_until(e + 400);
    wr(32'h0400_0002);
    wr(32'h0800_0002);
    e = last_edge;
    wait_until(e + 512);
    chk("R6 no expiry before reloaded due edge", {30'b0, expire_pulse, reset_req}, 32'd0);
    wait_until(e + 513);
    chk("R6 expiry at reloaded due edge", {30'b0, expire_pulse, reset_req}, 32'd3);

    // R8 preset change alone keeps the running count
    do_reset();
    wr(32'h0100_0002);
    wr(32'h0200_0002);
    e = last_edge;
    wr(32'h0000_0FFF);
    chk("R8 R3 preset readback", rd_data, 32'h8000_0FFF);
    wait_until(e + 512);
    chk("R8 no expiry before original due edge", {30'b0, expire_pulse, reset_req}, 32'd0);
    wait_until(e + 513);
    chk("R8 expiry at original due edge", {30'b0, expire_pulse, reset_req}, 32'd3);

    // R1 reset clears the request
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 R9 reset clears request", {30'b0, expire_pulse, reset_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    summary();
    $finish;
  end

endmodule